// File: doc/BRIEF.md
# Serial Shared-RAM Access Slave

This block lets an external controller reach a 1 kB dual-ported buffer over a four-wire serial link. The external controller is always the bus master. Each frame opens with a command byte and an address byte; after them the master either pushes data bytes that land in the buffer or clocks out data bytes read from it. The address steps forward after every data byte, so one frame can move a burst of any length.

The buffer's second port belongs to a local processor. That port has no wait or grant signal and is never stalled by remote traffic. Both sides may access the buffer in the same cycle. The serial pins are asynchronous to the system clock: they are synchronized and the serial clock is oversampled, so the serial clock must stay high and low for at least four system clocks at a time.

Top module: `shram_spi_bridge`

## Requirements
- R1: After reset, `loc_rdata` is 0 and `spi_miso` is 0.
- R2: The link uses SPI mode 0 with MSB first: MOSI is sampled on rising SCLK and MISO changes on falling SCLK. In the first byte of a frame, bit 7 selects read (1) or write (0), bits 1:0 give address bits 9:8, and bits 6:2 are ignored. The second byte gives address bits 7:0.
- R3: In a write frame, every complete data byte is stored at the current address. The store takes effect on the third rising system clock edge after the SCLK rising edge that completes the byte.
- R4: In a read frame, the buffer is read as soon as the address byte completes. The first data byte appears on MISO from the next falling SCLK edge.
- R5: The address increments by one after each data byte, with a carry into bits 9:8, and wraps from 0x3FF to 0x000.
- R6: Raising chip select ends the frame. A partly shifted byte is discarded and not written, and the next frame starts again with a command byte.
- R7: The local port writes when `loc_en` and `loc_we` are high and returns read data on `loc_rdata` one cycle after `loc_en` with `loc_we` low. It works regardless of remote traffic.
- R8: When both ports write the same address in the same cycle, the local processor's value is kept.
- R9: MISO is 0 while chip select is high and during the command and address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low frame select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| loc_en | input | 1 | Local port access enable |
| loc_we | input | 1 | Local port write enable |
| loc_addr | input | 10 | Local port byte address |
| loc_wdata | input | 8 | Local port write data |
| loc_rdata | output | 8 | Local port read data, one cycle latency |

## Verification
The local side preloads bytes around the 0x2FF/0x300 boundary, and a remote read burst then crosses that boundary. This shows that the carry into the upper address bits works and that read data meets the first falling edge after the address byte. A remote write burst that starts at 0x3FE shows the wrap to zero. Command bytes with the ignored bits set confirm that only bit 7 and bits 1:0 are decoded. A frame cut short in the middle of a byte shows that a partial byte is dropped while the full bytes before it are kept. Two same-address races hold the local write for either the third or only the second clock edge after the completing SCLK edge: one shows that the local write wins in a true collision, the other pins down the commit cycle of a remote write.

// File: rtl/shram_pkg.sv
package shram_pkg;
    localparam int BYTE_W = 8;
    localparam int RW_BIT = 7;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/shram_sync.sv
module shram_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi_s
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES-1:0] cs_n;
        logic [STAGES-1:0] mosi;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sck  = {s_q.sck[STAGES-1:0], sck};
        s_d.cs_n = {s_q.cs_n[STAGES-2:0], cs_n};
        s_d.mosi = {s_q.mosi[STAGES-2:0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sck  <= '0;
            s_q.cs_n <= '1;
            s_q.mosi <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck_rise = s_q.sck[STAGES-1] & ~s_q.sck[STAGES];
    assign sck_fall = ~s_q.sck[STAGES-1] & s_q.sck[STAGES];
    assign cs_act   = ~s_q.cs_n[STAGES-1];
    assign mosi_s   = s_q.mosi[STAGES-1];
endmodule

// File: rtl/shram_dpram.sv
module shram_dpram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] a_rd_d, a_rd_q, b_rd_d, b_rd_q;
    logic              a_wr, b_wr;

    // the local port takes priority on a same-address write race
    assign a_wr = a_en & a_we;
    assign b_wr = b_en & b_we & ~(a_wr && (a_addr == b_addr));

    always_ff @(posedge clk) begin
        if (b_wr) mem[b_addr] <= b_wdata;
        if (a_wr) mem[a_addr] <= a_wdata;
    end

    always_comb begin
        a_rd_d = a_rd_q;
        b_rd_d = b_rd_q;
        if (a_en && !a_we) a_rd_d = mem[a_addr];
        if (b_en && !b_we) b_rd_d = mem[b_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rd_q <= '0;
            b_rd_q <= '0;
        end else begin
            a_rd_q <= a_rd_d;
            b_rd_q <= b_rd_d;
        end
    end

    assign a_rdata = a_rd_q;
    assign b_rdata = b_rd_q;
endmodule

// File: rtl/shram_frame_ctrl.sv
module shram_frame_ctrl
    import shram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_act,
    input  logic              mosi_s,
    output logic              miso,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        phase_t             phase;
        logic [CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  tx;
        logic               rd;
        logic               load;
        logic               miso;
        logic [ADDR_W-1:0]  addr;
    } ctrl_t;

    ctrl_t             s_d, s_q;
    logic [BYTE_W-1:0] byte_in;
    logic [ADDR_W-1:0] next_addr;

    assign byte_in   = {s_q.rx[BYTE_W-2:0], mosi_s};
    assign next_addr = s_q.addr + 1'b1;

    always_comb begin
        s_d       = s_q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = s_q.addr;
        ram_wdata = byte_in;

        if (s_q.load) begin
            s_d.tx   = ram_rdata;
            s_d.load = 1'b0;
        end

        if (!cs_act) begin
            s_d.phase  = PH_CMD;
            s_d.bitcnt = '0;
            s_d.rd     = 1'b0;
            s_d.load   = 1'b0;
            s_d.tx     = '0;
            s_d.miso   = 1'b0;
        end else begin
            if (sck_fall) begin
                s_d.miso = s_q.tx[BYTE_W-1];
                s_d.tx   = {s_q.tx[BYTE_W-2:0], 1'b0};
            end
            if (sck_rise) begin
                s_d.rx     = byte_in;
                s_d.bitcnt = s_q.bitcnt + 1'b1;
                if (s_q.bitcnt == CNT_W'(BYTE_W - 1)) begin
                    unique case (s_q.phase)
                        PH_CMD: begin
                            s_d.rd    = byte_in[RW_BIT];
                            s_d.addr  = {byte_in[HI_W-1:0], {BYTE_W{1'b0}}};
                            s_d.phase = PH_ADDR;
                        end
                        PH_ADDR: begin
                            s_d.addr  = {s_q.addr[ADDR_W-1:BYTE_W], byte_in};
                            s_d.phase = PH_DATA;
                            if (s_q.rd) begin
                                ram_en   = 1'b1;
                                ram_addr = {s_q.addr[ADDR_W-1:BYTE_W], byte_in};
                                s_d.load = 1'b1;
                            end
                        end
                        default: begin
                            s_d.addr = next_addr;
                            ram_en   = 1'b1;
                            if (s_q.rd) begin
                                ram_addr = next_addr;
                                s_d.load = 1'b1;
                            end else begin
                                ram_we = 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_CMD, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign miso = s_q.miso;
endmodule

// File: rtl/shram_spi_bridge.sv
module shram_spi_bridge
    import shram_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              loc_en,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] loc_rdata
);
    logic              sck_rise, sck_fall, cs_act, mosi_s;
    logic              ram_b_en, ram_b_we;
    logic [ADDR_W-1:0] ram_b_addr;
    logic [BYTE_W-1:0] ram_b_wdata, ram_b_rdata;

    shram_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .mosi_s   (mosi_s)
    );

    shram_frame_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s),
        .miso      (spi_miso),
        .ram_en    (ram_b_en),
        .ram_we    (ram_b_we),
        .ram_addr  (ram_b_addr),
        .ram_wdata (ram_b_wdata),
        .ram_rdata (ram_b_rdata)
    );

    shram_dpram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (loc_en),
        .a_we    (loc_we),
        .a_addr  (loc_addr),
        .a_wdata (loc_wdata),
        .a_rdata (loc_rdata),
        .b_en    (ram_b_en),
        .b_we    (ram_b_we),
        .b_addr  (ram_b_addr),
        .b_wdata (ram_b_wdata),
        .b_rdata (ram_b_rdata)
    );
endmodule

// File: rtl/shram_bridge_chk.sv
module shram_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_miso,
    input logic cs_act,
    input logic sck_fall,
    input logic b_en,
    input logic b_we
);
    // R6
    remote_wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |-> cs_act);

    // R3
    one_wr_per_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |=> !b_we);

    // R4
    one_rd_per_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !b_we) |=> !b_en);

    // R2
    miso_on_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_fall) |=> $stable(spi_miso));
endmodule

bind shram_spi_bridge shram_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_miso (spi_miso),
    .cs_act   (cs_act),
    .sck_fall (sck_fall),
    .b_en     (ram_b_en),
    .b_we     (ram_b_we)
);

// File: tb/shram_spi_bridge_tb.sv
module shram_spi_bridge_tb;
    localparam int HP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       loc_en = 1'b0, loc_we = 1'b0;
    logic [9:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    always #4 clk = ~clk;

    shram_spi_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .loc_en(loc_en), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input string tag, input logic [7:0] exp, input logic [7:0] got);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        got_q.push_back(got);
    endtask

    // monitor: pops expected items and compares them with produced results
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && got_q.size() > 0)
                check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic spi_xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            #(HP);
            spi_sck = 1'b1;
            rx[i] = spi_miso;
            #(HP);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        #(HP);
    endtask

    task automatic cs_high();
        #(HP);
        spi_cs_n = 1'b1;
        #(2*HP);
    endtask

    task automatic loc_write(input logic [9:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        loc_en = 1'b1; loc_we = 1'b1; loc_addr = a; loc_wdata = d;
        @(posedge clk); #1;
        loc_en = 1'b0; loc_we = 1'b0;
    endtask

    task automatic loc_read(input logic [9:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        loc_en = 1'b1; loc_we = 1'b0; loc_addr = a;
        @(posedge clk); #1;
        loc_en = 1'b0;
        expect_item(tag, exp, loc_rdata);
    endtask

    task automatic hdr(input logic [7:0] cmd, input logic [7:0] lo, input string tag);
        logic [7:0] r;
        spi_xfer(cmd, r);
        expect_item({tag, " R9 miso zero in cmd byte"}, 8'h00, r);
        spi_xfer(lo, r);
        expect_item({tag, " R9 miso zero in addr byte"}, 8'h00, r);
    endtask

    // remote write where the local port writes the same address on the last SCLK rise
    task automatic race(input logic [9:0] a, input logic [7:0] ld, input logic [7:0] rd,
                        input int edges);
        logic [7:0] r;
        cs_low();
        hdr({6'b000000, a[9:8]}, a[7:0], "race");
        for (int i = 7; i >= 1; i--) spi_xfer_bit(rd[i]);
        spi_mosi = rd[0];
        #(HP);
        spi_sck = 1'b1;
        loc_en = 1'b1; loc_we = 1'b1; loc_addr = a; loc_wdata = ld;
        repeat (edges) @(posedge clk);
        #1;
        loc_en = 1'b0; loc_we = 1'b0;
        #(HP);
        spi_sck = 1'b0;
        cs_high();
        r = 8'h00;
    endtask

    task automatic spi_xfer_bit(input logic b);
        spi_mosi = b;
        #(HP);
        spi_sck = 1'b1;
        #(HP);
        spi_sck = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        #1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check("R1 loc_rdata after reset", loc_rdata, 8'h00);
        check("R1 miso after reset", {7'b0, spi_miso}, 8'h00);

        // R4 R5 R7: local preload, remote read burst across 0x2FF -> 0x300
        loc_write(10'h2FE, 8'h11);
        loc_write(10'h2FF, 8'h22);
        loc_write(10'h300, 8'h33);
        loc_write(10'h301, 8'h44);
        loc_read(10'h2FF, 8'h22, "R7 local readback");
        cs_low();
        hdr(8'h82, 8'hFE, "rd burst");
        spi_xfer(8'h00, r); expect_item("R4 first read byte", 8'h11, r);
        spi_xfer(8'h00, r); expect_item("R5 read incr", 8'h22, r);
        spi_xfer(8'h00, r); expect_item("R5 read carry into hi", 8'h33, r);
        spi_xfer(8'h00, r); expect_item("R5 read incr after carry", 8'h44, r);
        cs_high();
        check("R9 miso idle after frame", {7'b0, spi_miso}, 8'h00);

        // R3 R5: remote write burst wrapping past 0x3FF
        cs_low();
        hdr(8'h03, 8'hFE, "wr wrap");
        spi_xfer(8'hA1, r);
        spi_xfer(8'hB2, r);
        spi_xfer(8'hC3, r);
        cs_high();
        loc_read(10'h3FE, 8'hA1, "R3 remote write first");
        loc_read(10'h3FF, 8'hB2, "R5 remote write incr");
        loc_read(10'h000, 8'hC3, "R5 remote write wrap");

        // R2: ignored command bits 6:2
        loc_write(10'h110, 8'h5A);
        cs_low();
        hdr(8'hFD, 8'h10, "junk rd");
        spi_xfer(8'h00, r); expect_item("R2 read with bits 6:2 set", 8'h5A, r);
        cs_high();
        cs_low();
        hdr(8'h7E, 8'h40, "junk wr");
        spi_xfer(8'h66, r);
        cs_high();
        loc_read(10'h240, 8'h66, "R2 write with bits 6:2 set");

        // R6: aborted frame drops the partial byte
        loc_write(10'h051, 8'h99);
        cs_low();
        hdr(8'h00, 8'h50, "abort");
        spi_xfer(8'h77, r);
        for (int i = 7; i >= 3; i--) spi_xfer_bit(1'b1);
        cs_high();
        loc_read(10'h050, 8'h77, "R6 full byte kept");
        loc_read(10'h051, 8'h99, "R6 partial byte dropped");
        cs_low();
        hdr(8'h80, 8'h50, "after abort");
        spi_xfer(8'h00, r); expect_item("R6 next frame realigned", 8'h77, r);
        cs_high();

        // R8 and R3 commit cycle: same-address race with the local port
        race(10'h123, 8'hA5, 8'h3C, 3);
        loc_read(10'h123, 8'hA5, "R8 local wins same-cycle write");
        race(10'h124, 8'hA5, 8'h3C, 2);
        loc_read(10'h124, 8'h3C, "R3 remote commit on third clock edge");

        repeat (20) @(posedge clk);
        finish_run();
    end
endmodule